// File: doc/BRIEF.md
# Dual-Register Programmable Output Macrocell

This block is one output logic cell of a small programmable logic device. Each cell holds two registers, and each register takes its own sum-term data, clock and asynchronous clear. Static configuration sets each register to plain data (D) or toggle (T) behaviour. It also picks each register's clock from its own clock product term or from the shared clock pin. A further pair of bits picks registered or pass-through output and the output polarity. Both register values feed back to the array on their own, so either register can be kept off the pad. The pad level also has its own feedback path.

All product-term and pin clocks are treated as event signals. They are sampled by the system clock `clk`, and a register acts on the first `clk` edge where its selected clock source is seen high. The asynchronous clear terms act on the register outputs at once, with no clock edge. A shared synchronous preset and a test preload path force register state on clock events. Preload writes the raw pad level into the register named by a select input. The synchronous active-low `rst_n` models power-on reset.

Top module: `dual_reg_macrocell`

## Requirements
- R1: While `rst_n` is low, and after it rises, both registers read 0 on `fb_reg`. With registered output, `pad_out` then equals `cfg_invert`.
- R2: With `cfg_toggle_mode[i]`=0, a rising edge of register i's selected clock loads `sum_in[i]`. A clock held high causes no further loads.
- R3: With `cfg_toggle_mode[i]`=1, a clock event inverts register i when `sum_in[i]` is 1 and holds it when `sum_in[i]` is 0.
- R4: `cfg_pin_clock[i]`=1 clocks register i from `clk_pin`, and 0 clocks it from `clk_term[i]`. Edges on the source that is not selected have no effect.
- R5: While `areset[i]` is high, `fb_reg[i]` reads 0 at once, without a clock edge, and clock events do not set the register. The other register is not affected.
- R6: A clock event while `sync_preset` is high sets the register to 1. This takes priority over the D or T update. Asynchronous clear takes priority over the preset. With no clock event, the preset changes nothing.
- R7: While `preload_en` is high, a clock event on register i loads `pad_in` if `preload_sel` equals i (0 selects register 0, 1 selects register 1). Otherwise register i holds. Preload overrides preset and D/T updates. `cfg_invert` does not alter the loaded value.
- R8: With `cfg_registered`=1, `pad_out` is register 0 XOR `cfg_invert`. With `cfg_registered`=0, `pad_out` is `sum_in[0]` XOR `cfg_invert`, with no clock delay.
- R9: `pad_oe` follows `oe_term`. `fb_pad` equals `pad_out` while enabled and equals `pad_in` while disabled.
- R10: `fb_reg` shows both register values whatever the output enable and output path settings, so a register can be kept internal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all clock sources |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sum_in | input | NUM_REGS | Sum-term data input per register |
| clk_term | input | NUM_REGS | Clock product term per register |
| clk_pin | input | 1 | Shared dedicated clock pin |
| areset | input | NUM_REGS | Asynchronous clear term per register |
| sync_preset | input | 1 | Shared synchronous preset |
| oe_term | input | 1 | Output enable product term |
| cfg_toggle_mode | input | NUM_REGS | 1 = T behaviour, 0 = D behaviour, per register |
| cfg_pin_clock | input | NUM_REGS | 1 = clock from pin, 0 = clock from term, per register |
| cfg_registered | input | 1 | 1 = pad from register 0, 0 = pad from sum_in[0] |
| cfg_invert | input | 1 | Output polarity inversion |
| preload_en | input | 1 | Test preload mode |
| preload_sel | input | SEL_W | Register picked for preload |
| pad_in | input | 1 | Level applied to the pad from outside |
| pad_out | output | 1 | Value driven toward the pad |
| pad_oe | output | 1 | Pad driver enable (pad is Z when low) |
| fb_reg | output | NUM_REGS | Per-register feedback to the array |
| fb_pad | output | 1 | Pad level feedback to the array |

## Verification
A clocked result lands on the `clk` rising edge where the raised clock source is first sampled. So the bench raises a source on a falling edge and reads the register on the next falling edge, one half-period after the update. Asynchronous clear, output path selection, polarity and pad feedback have no register in their path. The bench checks them 1 ns after the input change, before any rising edge could hide a missing combinational path. Held-high clocks are kept high over several edges to show that loading happens only on the edge.

// File: rtl/mc_pkg.sv
// Package: shared encodings for the macrocell and the per-register next-state rule.
// Assumes: configuration values are static while clock sources are active.
package mc_pkg;

    typedef enum logic {
        CLK_FROM_TERM = 1'b0,
        CLK_FROM_PIN  = 1'b1
    } clk_src_e;

    typedef enum logic {
        KIND_D = 1'b0,
        KIND_T = 1'b1
    } reg_kind_e;

    // Next value of a register for a plain clocked update.
    function automatic logic dt_next(input reg_kind_e kind, input logic cur, input logic d);
        return (kind == KIND_T) ? (cur ^ d) : d;
    endfunction

endpackage

// File: rtl/mc_clk_edge.sv
// Module: picks a register's clock source and turns its rising level into a
// one-cycle event in the clk domain.
// Assumes: sources are slower than clk and stay high or low for at least one clk period.
module mc_clk_edge
    import mc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  clk_src_e src,
    input  logic     term_clk,
    input  logic     pin_clk,
    output logic     fire
);

    logic sel_lvl;
    logic prev_q;

    // Clock multiplexer between the product term and the pin.
    always_comb sel_lvl = (src == CLK_FROM_PIN) ? pin_clk : term_clk;

    // History of the selected level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sel_lvl;
    end

    assign fire = sel_lvl & ~prev_q;

    // An event is never seen on two cycles in a row for a single rise (R4).
    assert_single_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

endmodule

// File: rtl/mc_register.sv
// Module: one macrocell register with D/T behaviour, an asynchronous clear,
// a synchronous preset and a preload path.
// Assumes: fire is a single-cycle event; arst is applied straight to the output.
module mc_register
    import mc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  reg_kind_e kind,
    input  logic      fire,
    input  logic      arst,
    input  logic      preset,
    input  logic      pl_mode,
    input  logic      pl_pick,
    input  logic      pl_val,
    input  logic      sum,
    output logic      q
);

    logic state_q;
    logic state_d;

    // Priority: clear, then preload, then preset, then the D/T update.
    always_comb begin
        state_d = state_q;
        if (arst) begin
            state_d = 1'b0;
        end else if (fire) begin
            if (pl_mode)     state_d = pl_pick ? pl_val : state_q;
            else if (preset) state_d = 1'b1;
            else             state_d = dt_next(kind, state_q, sum);
        end
    end

    // Stored state with power-on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= 1'b0;
        else        state_q <= state_d;
    end

    // Clear acts at once on the visible value.
    assign q = state_q & ~arst;

    assert_poweron_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (state_q == 1'b0));

    assert_d_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && kind == KIND_D && !arst && !preset && !pl_mode) |=> (state_q == $past(sum)));

    assert_t_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && kind == KIND_T && sum && !arst && !preset && !pl_mode) |=> (state_q != $past(state_q)));

    assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !arst) |=> $stable(state_q));

    assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arst |=> (state_q == 1'b0));

    assert_preset_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && preset && !arst && !pl_mode) |=> state_q);

    assert_preload_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && pl_mode && pl_pick && !arst) |=> (state_q == $past(pl_val)));

    assert_preload_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_mode && !pl_pick && !arst) |=> $stable(state_q));

endmodule

// File: rtl/mc_output.sv
// Module: output path select, polarity, pad drive enable and pad feedback.
// Assumes: the pad itself is modelled outside; pad_in is the level applied externally.
module mc_output (
    input  logic cfg_registered,
    input  logic cfg_invert,
    input  logic reg_q,
    input  logic sum,
    input  logic oe_term,
    input  logic pad_in,
    output logic pad_out,
    output logic pad_oe,
    output logic fb_pad
);

    logic core;

    // Registered or pass-through source, then polarity.
    always_comb begin
        core    = cfg_registered ? reg_q : sum;
        pad_out = core ^ cfg_invert;
    end

    // Driver enable and the level seen back at the pad.
    always_comb begin
        pad_oe = oe_term;
        fb_pad = oe_term ? pad_out : pad_in;
    end

endmodule

// File: rtl/dual_reg_macrocell.sv
// Module: top of one output logic cell with NUM_REGS independently clocked
// registers, one of which (OUT_REG) can drive the pad.
// Assumes: configuration inputs are static while clock sources toggle.
module dual_reg_macrocell
    import mc_pkg::*;
#(
    parameter int NUM_REGS = 2,
    parameter int OUT_REG  = 0,
    localparam int SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] sum_in,
    input  logic [NUM_REGS-1:0] clk_term,
    input  logic                clk_pin,
    input  logic [NUM_REGS-1:0] areset,
    input  logic                sync_preset,
    input  logic                oe_term,
    input  logic [NUM_REGS-1:0] cfg_toggle_mode,
    input  logic [NUM_REGS-1:0] cfg_pin_clock,
    input  logic                cfg_registered,
    input  logic                cfg_invert,
    input  logic                preload_en,
    input  logic [SEL_W-1:0]    preload_sel,
    input  logic                pad_in,
    output logic                pad_out,
    output logic                pad_oe,
    output logic [NUM_REGS-1:0] fb_reg,
    output logic                fb_pad
);

    logic [NUM_REGS-1:0] fire;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        mc_clk_edge u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (clk_src_e'(cfg_pin_clock[i])),
            .term_clk (clk_term[i]),
            .pin_clk  (clk_pin),
            .fire     (fire[i])
        );

        mc_register u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .kind    (reg_kind_e'(cfg_toggle_mode[i])),
            .fire    (fire[i]),
            .arst    (areset[i]),
            .preset  (sync_preset),
            .pl_mode (preload_en),
            .pl_pick (preload_sel == SEL_W'(i)),
            .pl_val  (pad_in),
            .sum     (sum_in[i]),
            .q       (fb_reg[i])
        );
    end

    mc_output u_out (
        .cfg_registered (cfg_registered),
        .cfg_invert     (cfg_invert),
        .reg_q          (fb_reg[OUT_REG]),
        .sum            (sum_in[OUT_REG]),
        .oe_term        (oe_term),
        .pad_in         (pad_in),
        .pad_out        (pad_out),
        .pad_oe         (pad_oe),
        .fb_pad         (fb_pad)
    );

    assert_reg_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_registered |-> (pad_out == (fb_reg[OUT_REG] ^ cfg_invert)));

    assert_pad_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_term |-> (fb_pad == pad_in));

endmodule

// File: tb/tb_dual_reg_macrocell.sv
module tb_dual_reg_macrocell;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] sum_in, clk_term, areset, cfg_toggle_mode, cfg_pin_clock, fb_reg;
    logic       clk_pin, sync_preset, oe_term, cfg_registered, cfg_invert;
    logic       preload_en, pad_in, pad_out, pad_oe, fb_pad;
    logic [0:0] preload_sel;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dual_reg_macrocell dut (
        .clk(clk), .rst_n(rst_n), .sum_in(sum_in), .clk_term(clk_term),
        .clk_pin(clk_pin), .areset(areset), .sync_preset(sync_preset),
        .oe_term(oe_term), .cfg_toggle_mode(cfg_toggle_mode),
        .cfg_pin_clock(cfg_pin_clock), .cfg_registered(cfg_registered),
        .cfg_invert(cfg_invert), .preload_en(preload_en),
        .preload_sel(preload_sel), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .fb_reg(fb_reg), .fb_pad(fb_pad)
    );

    task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic pulse_term(input int i);
        @(negedge clk) clk_term[i] = 1'b1;
        @(negedge clk) clk_term[i] = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_pin();
        @(negedge clk) clk_pin = 1'b1;
        @(negedge clk) clk_pin = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_regs();
        @(negedge clk) areset = 2'b11;
        @(negedge clk) areset = 2'b00;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 regs in reset", fb_reg, 2'b00);
        check("R1 pad in reset", {1'b0, pad_out}, 2'b01);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 regs after reset", fb_reg, 2'b00);
        check("R1 pad after reset", {1'b0, pad_out}, 2'b01);
    endtask

    task automatic t_dmode();
        sum_in = 2'b01;
        pulse_term(0);
        check("R2 load one", fb_reg, 2'b01);
        check("R8 registered inverted", {1'b0, pad_out}, 2'b00);
        sum_in[0] = 1'b0;
        pulse_term(0);
        check("R2 load zero", fb_reg, 2'b00);
        sum_in[0] = 1'b1;
        @(negedge clk) clk_term[0] = 1'b1;
        @(negedge clk) sum_in[0] = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 held clock no reload", fb_reg, 2'b01);
        clk_term[0] = 1'b0;
        pulse_term(0);
        check("R2 next edge loads", fb_reg, 2'b00);
    endtask

    task automatic t_tmode();
        cfg_toggle_mode = 2'b10;
        sum_in = 2'b10;
        pulse_term(1);
        check("R3 toggle 1", fb_reg, 2'b10);
        pulse_term(1);
        check("R3 toggle 2", fb_reg, 2'b00);
        pulse_term(1);
        check("R3 toggle 3", fb_reg, 2'b10);
        sum_in = 2'b00;
        pulse_term(1);
        check("R3 hold with data low", fb_reg, 2'b10);
        cfg_toggle_mode = 2'b00;
        clear_regs();
    endtask

    task automatic t_clksel();
        cfg_pin_clock = 2'b01;
        sum_in = 2'b11;
        pulse_term(0);
        check("R4 term ignored when pin picked", fb_reg, 2'b00);
        pulse_pin();
        check("R4 pin clocks reg0 only", fb_reg, 2'b01);
        pulse_term(1);
        check("R4 term clocks reg1", fb_reg, 2'b11);
        cfg_pin_clock = 2'b00;
        clear_regs();
    endtask

    task automatic t_areset();
        sum_in = 2'b11;
        pulse_term(0);
        pulse_term(1);
        check("R5 setup", fb_reg, 2'b11);
        @(negedge clk) areset[0] = 1'b1;
        #1 check("R5 immediate clear", fb_reg, 2'b10);
        @(negedge clk) clk_term[0] = 1'b1;
        @(negedge clk);
        check("R5 clock during clear", fb_reg, 2'b10);
        clk_term[0] = 1'b0;
        areset[0]   = 1'b0;
        @(negedge clk);
        check("R5 stays clear after release", fb_reg, 2'b10);
        clear_regs();
    endtask

    task automatic t_preset();
        sync_preset = 1'b1;
        sum_in = 2'b00;
        repeat (2) @(negedge clk);
        check("R6 no event no change", fb_reg, 2'b00);
        pulse_term(0);
        check("R6 preset over D", fb_reg, 2'b01);
        cfg_toggle_mode = 2'b10;
        sum_in = 2'b10;
        pulse_term(1);
        check("R6 preset sets T reg", fb_reg, 2'b11);
        pulse_term(1);
        check("R6 preset over toggle", fb_reg, 2'b11);
        @(negedge clk) areset[0] = 1'b1;
        pulse_term(0);
        check("R6 clear over preset", fb_reg, 2'b10);
        areset[0] = 1'b0;
        sync_preset = 1'b0;
        cfg_toggle_mode = 2'b00;
        clear_regs();
    endtask

    task automatic t_preload();
        oe_term = 1'b0;
        cfg_invert = 1'b1;
        cfg_pin_clock = 2'b11;
        sum_in = 2'b11;
        preload_en = 1'b1;
        preload_sel = 1'b1;
        pad_in = 1'b1;
        pulse_pin();
        check("R7 load reg1, reg0 keeps", fb_reg, 2'b10);
        check("R10 feedback with pad off", {1'b0, pad_oe}, 2'b00);
        preload_sel = 1'b0;
        pad_in = 1'b0;
        sync_preset = 1'b1;
        pulse_pin();
        check("R7 preload over preset", fb_reg, 2'b10);
        pad_in = 1'b1;
        pulse_pin();
        check("R7 raw level despite invert", fb_reg, 2'b11);
        preload_en = 1'b0;
        sync_preset = 1'b0;
        sum_in = 2'b00;
        pulse_pin();
        check("R7 normal update resumes", fb_reg, 2'b00);
        cfg_pin_clock = 2'b00;
        oe_term = 1'b1;
    endtask

    task automatic t_outpath();
        cfg_registered = 1'b0;
        cfg_invert = 1'b0;
        @(negedge clk) sum_in[0] = 1'b1;
        #1 check("R8 pass-through high", {1'b0, pad_out}, 2'b01);
        @(negedge clk) sum_in[0] = 1'b0;
        #1 check("R8 pass-through low", {1'b0, pad_out}, 2'b00);
        @(negedge clk) cfg_invert = 1'b1;
        #1 check("R8 pass-through inverted", {1'b0, pad_out}, 2'b01);
        check("R10 reg unaffected by path", fb_reg, 2'b00);
        @(negedge clk) cfg_registered = 1'b1;
        #1 check("R8 registered zero inverted", {1'b0, pad_out}, 2'b01);
        sum_in[0] = 1'b1;
        pulse_term(0);
        check("R8 registered one inverted", {1'b0, pad_out}, 2'b00);
        @(negedge clk) cfg_invert = 1'b0;
        #1 check("R8 registered one plain", {1'b0, pad_out}, 2'b01);
    endtask

    task automatic t_oe();
        @(negedge clk) begin oe_term = 1'b0; pad_in = 1'b1; end
        #1 check("R9 pad released", {1'b0, pad_oe}, 2'b00);
        check("R9 fb from outside high", {1'b0, fb_pad}, 2'b01);
        @(negedge clk) pad_in = 1'b0;
        #1 check("R9 fb from outside low", {1'b0, fb_pad}, 2'b00);
        @(negedge clk) oe_term = 1'b1;
        #1 check("R9 pad driven", {1'b0, pad_oe}, 2'b01);
        check("R9 fb from driver", {1'b0, fb_pad}, 2'b01);
    endtask

    task automatic t_midreset();
        check("R1 before reset", fb_reg, 2'b01);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check("R1 reset clears", fb_reg, 2'b00);
    endtask

    initial begin
        rst_n = 1'b0; sum_in = '0; clk_term = '0; areset = '0;
        cfg_toggle_mode = '0; cfg_pin_clock = '0; clk_pin = 1'b0;
        sync_preset = 1'b0; oe_term = 1'b1; cfg_registered = 1'b1;
        cfg_invert = 1'b1; preload_en = 1'b0; preload_sel = '0; pad_in = 1'b0;
        t_reset();
        t_dmode();
        t_tmode();
        t_clksel();
        t_areset();
        t_preset();
        t_preload();
        t_outpath();
        t_oe();
        t_midreset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog got timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule